// File: doc/BRIEF.md
# Two-Level Bounds Table Walker

This block finds and moves the bounds record of a pointer by walking a two-level structure held in memory. A base input names the start of a directory. The pointer's storage address is split into a directory index (its top bits) and a table index (the bits just below). The walker reads the directory entry, which is either empty or the address of a bounds table. It then reads or writes the matching table entry. A table entry holds the lower bound, the upper bound and the pointer value those bounds belong to.

Requests arrive on a valid/ready port. Each one is a load or a store and carries the pointer's storage address. A store also carries the pointer value and both bounds. Memory is reached through a simple request/acknowledge port, and only one memory transaction is outstanding at a time. A load whose stored pointer value differs from the pointer supplied with the request returns open bounds. A walk that meets an empty directory entry ends with an error response and touches no table.

Top module: `bounds_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and `memReq` and `rspValid` are 0.
- R2: The first memory access of every walk is a read at `dirBase + dirIdx*8`. `dirIdx` is the top `DIR_IDX_W` bits of `reqAddr`.
- R3: A directory entry is valid only when its bit 0 is 1. On an invalid entry the walk issues no further memory access and responds with `rspErr` = 1.
- R4: The table entry base is the directory entry with its low 5 bits cleared, plus `tblIdx*32`. `tblIdx` is the `TBL_IDX_W` bits of `reqAddr` just below the directory index. The lower bound is at +0, the upper bound at +8 and the pointer value at +16.
- R5: A store (`reqStore` = 1) writes three words in the order lower, upper, pointer. Each write waits for the previous acknowledge, and the response follows the third acknowledge.
- R6: A load (`reqStore` = 0) reads the three words in the same order. When the stored pointer equals `reqPtr`, it returns the stored lower and upper bounds.
- R7: When a load's stored pointer differs from `reqPtr`, it returns `rspLower` = 0 and `rspUpper` = all ones.
- R8: `memReq`, `memAddr` and `memWe` stay steady until `memAck`. `reqReady` stays 0 from acceptance until the response cycle has passed.
- R9: `rspValid` is a one-cycle pulse in the cycle after the final acknowledge. `rspErr` is 0 for a walk that reached its table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirBase | input | ADDR_W | Directory base address |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Walker idle and accepting |
| reqStore | input | 1 | 1 = store bounds, 0 = load bounds |
| reqAddr | input | ADDR_W | Storage address of the pointer |
| reqPtr | input | ADDR_W | Pointer value |
| reqLower | input | ADDR_W | Lower bound to store |
| reqUpper | input | ADDR_W | Upper bound to store |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | ADDR_W | Memory write data |
| memAck | input | 1 | Memory acknowledge; read data valid |
| memRdata | input | ADDR_W | Memory read data |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Directory entry was empty |
| rspLower | output | ADDR_W | Returned lower bound (loads) |
| rspUpper | output | ADDR_W | Returned upper bound (loads) |

## Verification
The bench builds the walker with a 64-bit address and narrow indices: 4 directory bits and 3 table bits. With these widths, random requests reach every directory slot and every table slot, including the all-ones indices. Stores and later loads therefore land on the same entries often, which exercises both matching and mismatching pointer checks. Directory slots 12 to 15 are left empty or without bit 0. Slot 1 carries junk in bits 4:1, so random traffic regularly reaches the error path and the masking of the table base.

// File: rtl/bounds_walker_pkg.sv
package bounds_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RESP = 2'd3
  } walkState_t;

  typedef struct packed {
    logic takeReq;
    logic dirPhase;
    logic tblPhase;
    logic dirDone;
    logic wordDone;
  } walkStrobe_t;

  localparam int unsigned ENTRY_WORDS = 3;

endpackage

// File: rtl/bounds_walker_ctrl.sv
module bounds_walker_ctrl
  import bounds_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memAck,
  input  logic        dirOk,
  input  logic        lastWord,
  output logic        reqReady,
  output logic        memReq,
  output logic        rspValid,
  output walkStrobe_t st
);

  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_DIR;
      ST_DIR:  if (memAck) stateNext = dirOk ? ST_TBL : ST_RESP;
      ST_TBL:  if (memAck && lastWord) stateNext = ST_RESP;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_DIR) || (state == ST_TBL);
  assign rspValid = (state == ST_RESP);

  always_comb begin
    st.takeReq  = (state == ST_IDLE) && reqValid;
    st.dirPhase = (state == ST_DIR);
    st.tblPhase = (state == ST_TBL);
    st.dirDone  = (state == ST_DIR) && memAck;
    st.wordDone = (state == ST_TBL) && memAck;
  end

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.takeReq |=> (!reqReady && memReq));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  assert_bad_dir_no_table_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.dirDone && !dirOk) |=> (!memReq && rspValid));

endmodule

// File: rtl/bounds_walker_dp.sv
module bounds_walker_dp
  import bounds_walker_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DIR_IDX_W = 20,
  parameter int unsigned TBL_IDX_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       st,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqPtr,
  input  logic [ADDR_W-1:0] reqLower,
  input  logic [ADDR_W-1:0] reqUpper,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic              dirOk,
  output logic              lastWord,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspLower,
  output logic [ADDR_W-1:0] rspUpper
);

  localparam int unsigned WORD_BYTES = ADDR_W / 8;
  localparam int unsigned WB_SHIFT   = $clog2(WORD_BYTES);
  localparam int unsigned TBL_SHIFT  = WB_SHIFT + 2;
  localparam int unsigned LOW_W      = ADDR_W - DIR_IDX_W - TBL_IDX_W;

  logic [DIR_IDX_W-1:0] dirIdxR;
  logic [TBL_IDX_W-1:0] tblIdxR;
  logic [ADDR_W-1:0]    ptrR, lowerR, upperR, tableBaseR;
  logic [1:0]           wordIdx;
  logic                 storeR, errR, matchR;

  logic unusedLow;
  assign unusedLow = ^reqAddr[LOW_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirIdxR    <= '0;
      tblIdxR    <= '0;
      ptrR       <= '0;
      lowerR     <= '0;
      upperR     <= '0;
      tableBaseR <= '0;
      wordIdx    <= '0;
      storeR     <= 1'b0;
      errR       <= 1'b0;
      matchR     <= 1'b1;
    end else begin
      if (st.takeReq) begin
        dirIdxR <= reqAddr[ADDR_W-1 -: DIR_IDX_W];
        tblIdxR <= reqAddr[ADDR_W-DIR_IDX_W-1 -: TBL_IDX_W];
        ptrR    <= reqPtr;
        lowerR  <= reqLower;
        upperR  <= reqUpper;
        storeR  <= reqStore;
        wordIdx <= '0;
        errR    <= 1'b0;
        matchR  <= 1'b1;
      end
      if (st.dirDone) begin
        tableBaseR <= {memRdata[ADDR_W-1:TBL_SHIFT], {TBL_SHIFT{1'b0}}};
        errR       <= !memRdata[0];
      end
      if (st.wordDone) begin
        wordIdx <= wordIdx + 2'd1;
        if (!storeR) begin
          case (wordIdx)
            2'd0:    lowerR <= memRdata;
            2'd1:    upperR <= memRdata;
            default: matchR <= (memRdata == ptrR);
          endcase
        end
      end
    end
  end

  logic [ADDR_W-1:0] dirOff, tblOff, wordOff;
  assign dirOff  = ADDR_W'(dirIdxR) << WB_SHIFT;
  assign tblOff  = ADDR_W'(tblIdxR) << TBL_SHIFT;
  assign wordOff = ADDR_W'(wordIdx) << WB_SHIFT;

  assign memAddr = st.tblPhase ? (tableBaseR + tblOff + wordOff) : (dirBase + dirOff);
  assign memWe   = st.tblPhase && storeR;

  always_comb begin
    case (wordIdx)
      2'd0:    memWdata = lowerR;
      2'd1:    memWdata = upperR;
      default: memWdata = ptrR;
    endcase
  end

  assign dirOk    = memRdata[0];
  assign lastWord = (wordIdx == 2'(ENTRY_WORDS - 1));
  assign rspErr   = errR;
  assign rspLower = matchR ? lowerR : '0;
  assign rspUpper = matchR ? upperR : '1;

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((st.dirPhase || st.tblPhase) && !memAck) |=> ($stable(memAddr) && $stable(memWe)));

  assert_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.wordDone && !lastWord) |=> (st.tblPhase && !lastWord || st.tblPhase));

endmodule

// File: rtl/bounds_walker.sv
module bounds_walker
  import bounds_walker_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DIR_IDX_W = 20,
  parameter int unsigned TBL_IDX_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqPtr,
  input  logic [ADDR_W-1:0] reqLower,
  input  logic [ADDR_W-1:0] reqUpper,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspLower,
  output logic [ADDR_W-1:0] rspUpper
);

  walkStrobe_t st;
  logic        dirOk, lastWord;

  bounds_walker_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memAck   (memAck),
    .dirOk    (dirOk),
    .lastWord (lastWord),
    .reqReady (reqReady),
    .memReq   (memReq),
    .rspValid (rspValid),
    .st       (st)
  );

  bounds_walker_dp #(
    .ADDR_W    (ADDR_W),
    .DIR_IDX_W (DIR_IDX_W),
    .TBL_IDX_W (TBL_IDX_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .dirBase  (dirBase),
    .reqStore (reqStore),
    .reqAddr  (reqAddr),
    .reqPtr   (reqPtr),
    .reqLower (reqLower),
    .reqUpper (reqUpper),
    .memAck   (memAck),
    .memRdata (memRdata),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .dirOk    (dirOk),
    .lastWord (lastWord),
    .rspErr   (rspErr),
    .rspLower (rspLower),
    .rspUpper (rspUpper)
  );

endmodule

// File: tb/test_bounds_walker.sv
`timescale 1ns/1ps
module test_bounds_walker;

  localparam int AW = 64;
  localparam int DW = 4;
  localparam int TW = 3;
  localparam logic [AW-1:0] DIR_BASE = 64'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqStore = 1'b0, memAck = 1'b0;
  logic [AW-1:0] reqAddr = '0, reqPtr = '0, reqLower = '0, reqUpper = '0, memRdata = '0;
  logic reqReady, memReq, memWe, rspValid, rspErr;
  logic [AW-1:0] memAddr, memWdata, rspLower, rspUpper;

  always #2.5 clk = ~clk;

  bounds_walker #(.ADDR_W(AW), .DIR_IDX_W(DW), .TBL_IDX_W(TW)) i_bounds_walker (
    .clk(clk), .rstN(rstN), .dirBase(DIR_BASE),
    .reqValid(reqValid), .reqReady(reqReady), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqPtr(reqPtr), .reqLower(reqLower), .reqUpper(reqUpper),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspLower(rspLower), .rspUpper(rspUpper)
  );

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] mem [logic [AW-1:0]];
  logic [AW-1:0] logAddr [$];
  logic [AW-1:0] logData [$];
  logic          logWe   [$];
  logic [AW-1:0] refLo [128];
  logic [AW-1:0] refUp [128];
  logic [AW-1:0] refPtr [128];
  int waitCnt = 0;

  task automatic chk(input logic ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] tblBase(input int d);
    return 64'h1000_0000 + AW'(d) * 64'h10_0000;
  endfunction

  function automatic logic dirValid(input int d);
    return d < 12;
  endfunction

  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt == 0) begin
        logAddr.push_back(memAddr);
        logWe.push_back(memWe);
        if (memWe) begin
          mem[memAddr] = memWdata;
          logData.push_back(memWdata);
        end else begin
          memRdata = mem.exists(memAddr) ? mem[memAddr] : '0;
          logData.push_back(memRdata);
        end
        memAck = 1'b1;
        waitCnt = $urandom % 3;
      end else waitCnt--;
    end
  end

  task automatic doOp(input logic store, input int d, input int t,
                      input logic [AW-1:0] ptr, input logic [AW-1:0] lo, input logic [AW-1:0] up);
    logic busyOk;
    logic [AW-1:0] gotLo, gotUp, eLo, eUp, tb;
    logic gotErr;
    int key;
    key = d * 8 + t;
    logAddr.delete(); logWe.delete(); logData.delete();
    @(negedge clk);
    reqValid = 1'b1; reqStore = store;
    reqAddr = {4'(d), 3'(t), 57'({$urandom, $urandom})};
    reqPtr = ptr; reqLower = lo; reqUpper = up;
    @(negedge clk);
    reqValid = 1'b0;
    busyOk = 1'b1;
    while (!rspValid) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
    end
    gotLo = rspLower; gotUp = rspUpper; gotErr = rspErr;
    chk(busyOk, "R8 ready low while busy", AW'(busyOk), 64'h1);
    @(negedge clk);
    chk(!rspValid && reqReady, "R9 response is one pulse", AW'({rspValid, reqReady}), 64'h1);
    chk(logAddr.size() > 0 && logAddr[0] == DIR_BASE + AW'(d) * 8 && !logWe[0],
        "R2 directory read address", logAddr.size() > 0 ? logAddr[0] : '0, DIR_BASE + AW'(d) * 8);
    if (!dirValid(d)) begin
      chk(logAddr.size() == 1, "R3 no table access after empty entry", AW'(logAddr.size()), 64'h1);
      chk(gotErr, "R3 error response", AW'(gotErr), 64'h1);
    end else begin
      tb = tblBase(d) + AW'(t) * 32;
      chk(!gotErr, "R9 no error on valid walk", AW'(gotErr), 64'h0);
      chk(logAddr.size() == 4, "R4 four accesses", AW'(logAddr.size()), 64'h4);
      if (logAddr.size() == 4) begin
        for (int i = 0; i < 3; i++) begin
          chk(logAddr[i+1] == tb + AW'(i) * 8, "R4 table word address", logAddr[i+1], tb + AW'(i) * 8);
          chk(logWe[i+1] == store, store ? "R5 write enable" : "R6 read enable", AW'(logWe[i+1]), AW'(store));
        end
        if (store) begin
          chk(logData[1] == lo, "R5 first write lower", logData[1], lo);
          chk(logData[2] == up, "R5 second write upper", logData[2], up);
          chk(logData[3] == ptr, "R5 third write pointer", logData[3], ptr);
        end
      end
      if (store) begin
        refLo[key] = lo; refUp[key] = up; refPtr[key] = ptr;
      end else begin
        if (refPtr[key] == ptr) begin
          eLo = refLo[key]; eUp = refUp[key];
          chk(gotLo == eLo, "R6 lower bound", gotLo, eLo);
          chk(gotUp == eUp, "R6 upper bound", gotUp, eUp);
        end else begin
          chk(gotLo == '0, "R7 open lower bound", gotLo, '0);
          chk(gotUp == '1, "R7 open upper bound", gotUp, '1);
        end
      end
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 128; i++) begin
      refLo[i] = '0; refUp[i] = '0; refPtr[i] = '0;
    end
    for (int d = 0; d < 12; d++)
      mem[DIR_BASE + AW'(d) * 8] = tblBase(d) | (d == 1 ? 64'h1F : 64'h1);
    mem[DIR_BASE + 12 * 8] = 64'h2000_0000;
    repeat (3) @(negedge clk);
    chk(reqReady && !memReq && !rspValid, "R1 reset state",
        AW'({reqReady, memReq, rspValid}), 64'h4);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !memReq && !rspValid, "R1 idle after reset",
        AW'({reqReady, memReq, rspValid}), 64'h4);

    doOp(1'b1, 0, 0, 64'hAAAA_0000, 64'h100, 64'h1FF);
    doOp(1'b0, 0, 0, 64'hAAAA_0000, '0, '0);
    doOp(1'b0, 0, 0, 64'hBBBB_0000, '0, '0);
    doOp(1'b1, 1, 5, 64'h1234, 64'h40, 64'h7F);
    doOp(1'b0, 1, 5, 64'h1234, '0, '0);
    doOp(1'b1, 11, 7, 64'hFFFF_FFFF_FFFF_FFF8, 64'h8, 64'hFFFF);
    doOp(1'b0, 11, 7, 64'hFFFF_FFFF_FFFF_FFF8, '0, '0);
    doOp(1'b0, 12, 2, 64'h1, '0, '0);
    doOp(1'b1, 15, 7, 64'h2, 64'h3, 64'h4);
    doOp(1'b0, 3, 3, 64'h0, '0, '0);

    for (int n = 0; n < 80; n++) begin
      int d, t;
      logic [AW-1:0] p;
      d = $urandom % 16;
      t = $urandom % 8;
      p = ($urandom % 2) ? refPtr[d * 8 + t] : {$urandom, $urandom};
      doOp(1'($urandom % 2), d, t, p, {$urandom, $urandom}, {$urandom, $urandom});
    end
    finishRun();
  end

endmodule